// File: doc/BRIEF.md
# Paged Digital I/O Interrupt Controller

This block provides 24 digital I/O lines, grouped as three 8-bit ports, behind an 8-bit register bus that decodes a 16-byte window. Each line can latch a transition interrupt. A combined level-sensitive interrupt output tells the host that at least one line is waiting for service.

Three offsets (8, 9 and 10) are shared by two register banks. A page register at offset 7 chooses which bank they show: the per-port interrupt enable masks or the per-port interrupt identification flags. A master pending register reports which ports hold a pending flag. This lets a handler narrow the search to a port before it reads the identification bank.

Software services a line by writing its enable bit to 0, which clears the pending flag. It then writes the bit back to 1, which arms the line for its next rising edge. Reads have no side effects, and the read data is combinational from the address.

Top module: `pdio_irq_ctrl`

## Requirements
- R1: After reset the page register is page 0, all enable masks and pending flags are 0, `irq_o` is low and `pin_o` is 0.
- R2: A write to offset 0, 1 or 2 sets output byte 0, 1 or 2 of `pin_o` on the next clock edge. A read of those offsets returns `pin_i` of that port through a two-flop synchronizer.
- R3: Offset 7 stores write-data bits 7:6 as the page code and reads back as that code with bits 5:0 zero. 0x00 selects page 0, 0x80 selects page 2 (enables) and 0xC0 selects page 3 (identification).
- R4: With page 2 selected, offsets 8, 9 and 10 read and write the interrupt enable masks of ports 0, 1 and 2.
- R5: With page 3 selected, offsets 8, 9 and 10 read the pending flags of ports 0, 1 and 2. Writes to those offsets are ignored and leave the enable masks unchanged.
- R6: A pending flag is set only by a rising edge on its synchronized line while its enable bit is 1. The flag is readable on the third rising clock edge after the pin changes. A falling edge, or a rising edge on a disabled line, sets nothing.
- R7: Writing 0 to an enable bit clears that line's pending flag. Writing 1 back re-arms the line without setting the flag until the next rising edge.
- R8: Offset 6 reads the master pending register: bit n is 1 when port n has any pending flag, and bits 7:3 read 0.
- R9: `irq_o` is the OR of the three master pending bits. It stays high until every pending flag is cleared.
- R10: Line k (1 to 24) maps to port (k-1)/8, bit (k-1)%8, for pins, enables and pending flags alike.
- R11: With page 0 (or the unused code 01) selected, offsets 8 to 10 read 0 and ignore writes. Offsets 3 to 5 and 11 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_i | input | 24 | Asynchronous line inputs |
| pin_o | output | 24 | Output latch for the lines |
| irq_o | output | 1 | Combined level interrupt |

## Verification
A wrong enable or pending bit shows up within one cycle as a wrong master pending bit or a wrong `irq_o` level. It shows up exactly at the ports when the relevant page is read back. A broken edge detector or synchronizer shows as a flag that appears a cycle early or late after a pin change, or appears on a falling edge. The bench samples these at their exact cycle. A page decode fault shows as enable masks that change under page 3, or as page 2 data that appears under page 0. Both are read back at once.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int NUM_PORT = 3;

    localparam logic [ADDR_W-1:0] OFS_MASTER = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_PAGE   = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_BANK0  = 4'd8;

    typedef enum logic [1:0] {
        PG_DATA = 2'b00,
        PG_RSV  = 2'b01,
        PG_IEN  = 2'b10,
        PG_IID  = 2'b11
    } page_e;

    typedef struct packed {
        logic                    valid;
        logic [1:0]              idx;
    } port_sel_t;

    function automatic port_sel_t sel_data(input logic [ADDR_W-1:0] a);
        port_sel_t s;
        s.valid = (a < ADDR_W'(NUM_PORT));
        s.idx   = a[1:0];
        return s;
    endfunction

    function automatic port_sel_t sel_bank(input logic [ADDR_W-1:0] a);
        port_sel_t s;
        logic [ADDR_W-1:0] rel;
        rel     = a - OFS_BANK0;
        s.valid = (a >= OFS_BANK0) && (rel < ADDR_W'(NUM_PORT));
        s.idx   = rel[1:0];
        return s;
    endfunction
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pdio_port_irq.sv
module pdio_port_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_i,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] en_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] en_d;
    logic [W-1:0] rise;

    assign rise = line_i & ~prev_q;
    assign en_d = en_we ? en_wdata : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= line_i;
            en_q   <= en_d;
            pend_q <= (pend_q | (rise & en_q)) & en_d;
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;

    AST_PEND_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise & en_q)) == '0)); // R6

    AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        en_we |=> ((pend_q & ~$past(en_wdata)) == '0)); // R7

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> ((($past(pend_q)) & ~pend_q) == '0)); // R9
endmodule

// File: rtl/pdio_irq_ctrl.sv
module pdio_irq_ctrl
    import pdio_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int NPORT  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NPORT*PORT_W-1:0] pin_i,
    output logic [NPORT*PORT_W-1:0] pin_o,
    output logic                    irq_o
);
    localparam int LINES = NPORT * PORT_W;

    page_e             page_q;
    logic [LINES-1:0]  sync_w;
    logic [LINES-1:0]  en_w;
    logic [LINES-1:0]  pend_w;
    logic [LINES-1:0]  out_q;
    logic [NPORT-1:0]  master_w;
    logic [NPORT-1:0]  en_we;
    port_sel_t         dsel;
    port_sel_t         bsel;

    assign dsel = sel_data(bus_addr);
    assign bsel = sel_bank(bus_addr);

    pdio_sync #(.W(LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (sync_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= PG_DATA;
        end else if (bus_wr && bus_addr == OFS_PAGE) begin
            page_q <= page_e'(bus_wdata[7:6]);
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port
            assign en_we[gp] = bus_wr && bsel.valid && (page_q == PG_IEN)
                               && (bsel.idx == 2'(gp));

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q[gp*PORT_W +: PORT_W] <= '0;
                end else if (bus_wr && dsel.valid && dsel.idx == 2'(gp)) begin
                    out_q[gp*PORT_W +: PORT_W] <= bus_wdata[PORT_W-1:0];
                end
            end

            pdio_port_irq #(.W(PORT_W)) u_port (
                .clk      (clk),
                .rst      (rst),
                .line_i   (sync_w[gp*PORT_W +: PORT_W]),
                .en_we    (en_we[gp]),
                .en_wdata (bus_wdata[PORT_W-1:0]),
                .en_o     (en_w[gp*PORT_W +: PORT_W]),
                .pend_o   (pend_w[gp*PORT_W +: PORT_W])
            );

            assign master_w[gp] = |pend_w[gp*PORT_W +: PORT_W];
        end
    endgenerate

    assign pin_o = out_q;
    assign irq_o = |master_w;

    always_comb begin
        bus_rdata = '0;
        if (dsel.valid) begin
            bus_rdata[PORT_W-1:0] = sync_w[dsel.idx*PORT_W +: PORT_W];
        end else if (bus_addr == OFS_MASTER) begin
            bus_rdata[NPORT-1:0] = master_w;
        end else if (bus_addr == OFS_PAGE) begin
            bus_rdata[7:6] = page_q;
        end else if (bsel.valid) begin
            case (page_q)
                PG_IEN:  bus_rdata[PORT_W-1:0] = en_w[bsel.idx*PORT_W +: PORT_W];
                PG_IID:  bus_rdata[PORT_W-1:0] = pend_w[bsel.idx*PORT_W +: PORT_W];
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && en_we == '0) |=> irq_o); // R9

    AST_IID_PAGE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bsel.valid && page_q != PG_IEN) |=> (en_w == $past(en_w))); // R5

    AST_MASTER_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_MASTER) |-> (bus_rdata[7:NPORT] == '0)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en_w != '0)); // R7
endmodule

// File: tb/pdio_irq_ctrl_tb_top.sv
module pdio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_i;
    logic [23:0] pin_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [23:0] m_en;
    logic [23:0] m_pend;
    logic [23:0] m_pin;

    always #2.5 clk = ~clk;

    pdio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [2:0] exp_master(input logic [23:0] p);
        return {|p[23:16], |p[15:8], |p[7:0]};
    endfunction

    task automatic set_en(input int port, input logic [7:0] m);
        wr(4'd7, 8'h80);
        wr(4'(8 + port), m);
        m_en[port*8 +: 8]   = m;
        m_pend[port*8 +: 8] = m_pend[port*8 +: 8] & m;
    endtask

    task automatic drive_pins(input logic [23:0] v);
        @(negedge clk);
        m_pend = m_pend | (v & ~m_pin & m_en);
        m_pin  = v;
        pin_i  = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        wr(4'd7, 8'hC0);
        for (int p = 0; p < 3; p++) begin
            rd(4'(8 + p), d);
            chk({tag, " R5 id"}, d, m_pend[p*8 +: 8]);
        end
        wr(4'd7, 8'h80);
        for (int p = 0; p < 3; p++) begin
            rd(4'(8 + p), d);
            chk({tag, " R4 en"}, d, m_en[p*8 +: 8]);
        end
        rd(4'd6, d);
        chk({tag, " R8 master"}, d, {5'b0, exp_master(m_pend)});
        chk({tag, " R9 irq"}, irq_o, |m_pend);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_i = '0;
        m_en = '0; m_pend = '0; m_pin = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd7, d);     chk("R1 page", d, 8'h00);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 pin_o", pin_o, 24'h0);
        check_all("R1");

        // R2 data path
        wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'hF0);
        chk("R2 pin_o", pin_o, 24'hF03CA5);
        drive_pins(24'h123456);
        rd(4'd0, d); chk("R2 rd p0", d, 8'h56);
        rd(4'd2, d); chk("R2 rd p2", d, 8'h12);
        drive_pins(24'h0);

        // R3 page readback
        wr(4'd7, 8'hFF); rd(4'd7, d); chk("R3 page rb", d, 8'hC0);
        wr(4'd7, 8'h80); rd(4'd7, d); chk("R3 page rb2", d, 8'h80);

        // R11 page 0 hides bank, writes ignored
        set_en(1, 8'h0F);
        wr(4'd7, 8'h00); rd(4'd9, d); chk("R11 p0 read", d, 8'h00);
        wr(4'd9, 8'hFF);
        wr(4'd7, 8'h40); wr(4'd9, 8'hFF); rd(4'd9, d); chk("R11 rsv read", d, 8'h00);
        rd(4'd4, d);  chk("R11 ofs4", d, 8'h00);
        rd(4'd13, d); chk("R11 ofs13", d, 8'h00);
        check_all("R11");

        // R5 writes under page 3 ignored
        wr(4'd7, 8'hC0); wr(4'd9, 8'hAA);
        check_all("R5 wr");

        // R6 exact timing: line 9 (port1 bit0), R10
        wr(4'd7, 8'hC0);
        bus_addr = 4'd9;
        @(negedge clk); pin_i = 24'h000100;
        @(negedge clk); @(negedge clk);
        #0.5 chk("R6 not yet", bus_rdata, 8'h00);
        @(negedge clk);
        #0.5 chk("R6 set at 3rd edge", bus_rdata, 8'h01);
        m_pin = 24'h000100; m_pend[8] = 1'b1;
        repeat (2) @(negedge clk);
        // falling edge sets nothing
        drive_pins(24'h0);
        check_all("R6 fall");
        // disabled line: line 24
        drive_pins(24'h800000);
        check_all("R6 disabled");
        drive_pins(24'h0);

        // R7 clear and rearm, R9 level
        chk("R9 irq held", irq_o, 1'b1);
        set_en(1, 8'h0E);
        check_all("R7 clear");
        chk("R9 irq low", irq_o, 1'b0);
        set_en(1, 8'h0F);
        check_all("R7 rearm");

        // R10 line mapping: lines 1, 16, 17
        set_en(0, 8'h01); set_en(1, 8'h80); set_en(2, 8'h01);
        drive_pins(24'h018001);
        check_all("R10 map");
        wr(4'd7, 8'h80);
        for (int p = 0; p < 3; p++) set_en(p, 8'h00);
        drive_pins(24'h0);
        check_all("R10 clr");

        // random mix
        for (int i = 0; i < 200; i++) begin
            int op;
            op = $urandom_range(0, 2);
            if (op == 0) set_en($urandom_range(0, 2), 8'($urandom));
            else drive_pins(24'($urandom));
            if (i % 10 == 9) check_all("RND R6 R7");
        end
        check_all("final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule